// File: doc/BRIEF.md
# RS-485 Half-Duplex Direction Controller

This block sits beside a UART transmitter and receiver and decides which way a half-duplex line points. It holds one 8-bit alternate-function configuration register that the host writes. From that register it drives the enable pin of an external RS-485 line driver. The enable goes high as soon as transmit data is waiting. It stays high while the transmit FIFO or the transmit shift register holds a character. After both have drained, it stays high for a programmable number of bit times, so that the last stop bit can travel down a long cable before the line is released.

The same register controls interrupts and the receiver. In RS-485 mode, transmit interrupt requests are held back until the shift register is empty, unless the host has marked the transfer as a large block. The controller also decides whether received characters may be stored and whether the character-timeout interrupt is allowed. It takes into account the RS-485 and IrDA half-duplex modes, a receive-snoop enable and the loopback flag.

The serializer, the FIFOs, the baud generator and the IrDA pulse shaping are outside this block. They supply its status inputs and the one-cycle bit-time tick.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: A host write loads the configuration register only when `wr_addr` is 3'b010 and `bank_sel` is 3'b100. Any other write leaves the register, and so all outputs, unchanged.
- R2: After reset every configuration bit is zero. At reset `drv_en` is 0, `rx_store_en` is 1, `rx_timeout_en` is 0, and `tx_irq` follows the normal RS-232 rule.
- R3: Configuration bit 2 enables RS-485. With it set, `drv_en` is 1 from the clock edge after a cycle in which `txfifo_empty` is 0, `tsr_empty` is 0 or `thr_write` is 1.
- R4: Bits 7:5 hold a delay D. Once both `txfifo_empty` and `tsr_empty` are 1, `drv_en` stays 1 and falls on the edge that samples the (D+1)-th `bit_tick` pulse. Ticks that arrive while data is pending do not count.
- R5: A `thr_write` pulse during the countdown cancels it. `drv_en` stays 1, and the full D+1 tick count starts again once both stages are empty.
- R6: With bit 2 clear, `drv_en` is 0 from the edge after the configuration register shows it clear, including in the middle of a countdown.
- R7: Normally `tx_irq` = `tx_below_thr` OR `txfifo_empty`. When bit 2 is 1 and bit 3 (large block) is 0, `tx_irq` is additionally ANDed with `tsr_empty`. When bit 3 is set, the normal rule applies.
- R8: When bit 4 (receive enable) is 0, either bit 2 or bit 1 (IrDA) is 1, and `loopback` is 0, `rx_store_en` is 0. In every other combination it is 1.
- R9: `rx_timeout_en` equals bit 4 in every mode, including plain RS-232 and loopback.
- R10: With `loopback` at 1, `rx_store_en` is 1 whatever the mode bits and bit 4 hold.
- R11: Bit 0 has no effect on any output. Bit 1 alone never raises `drv_en` and leaves `tx_irq` on the normal rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register offset |
| bank_sel | input | 3 | Register bank select (line-control bits 7:5) |
| wr_data | input | 8 | Host write data |
| thr_write | input | 1 | Pulse: a character was written to the transmit holding register |
| txfifo_empty | input | 1 | Transmit FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| tx_below_thr | input | 1 | Transmit FIFO level is below its threshold |
| loopback | input | 1 | Internal loopback mode is active |
| drv_en | output | 1 | RS-485 line driver enable |
| tx_irq | output | 1 | Gated transmit interrupt request |
| rx_store_en | output | 1 | Received characters may be stored |
| rx_timeout_en | output | 1 | Character-timeout interrupt is permitted |

## Verification
There are two main ways a wrong countdown shows up. A counter that is loaded or decremented wrongly moves the falling edge of `drv_en` by whole tick periods, so that edge is sampled exactly at the D-th and (D+1)-th ticks. A sequencer that is stuck in its hold state keeps `drv_en` high indefinitely, and this shows up within one tick. The gating outputs are combinational on the register, so a bad field decode or a wrong write qualification is visible on `tx_irq`, `rx_store_en` or `rx_timeout_en` in the first cycle after the write. Every mode and flag combination is therefore compared in a table walk.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

    localparam int ADDR_W  = 3;
    localparam int BANK_W  = 3;
    localparam int DATA_W  = 8;
    localparam int DLY_W   = 3;

    localparam logic [ADDR_W-1:0] AFN_OFFSET = 3'b010;
    localparam logic [BANK_W-1:0] AFN_BANK   = 3'b100;

    // Field layout of the alternate-function byte (host visible positions).
    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             rcv_en;
        logic             large_blk;
        logic             rs485_en;
        logic             ir_en;
        logic             rsvd;
    } afn_cfg_t;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_SEND = 2'd1,
        DS_HOLD = 2'd2
    } drv_state_t;

    function automatic logic tx_data_pending(input logic fifo_empty,
                                             input logic shift_empty,
                                             input logic holding_wr);
        return (!fifo_empty) || (!shift_empty) || holding_wr;
    endfunction

    function automatic logic rx_store_allowed(input logic half_duplex,
                                              input logic snoop,
                                              input logic lb);
        return lb || snoop || !half_duplex;
    endfunction

endpackage

// File: rtl/rs485_afn_regs.sv
module rs485_afn_regs
    import rs485_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] wr_data,
    output afn_cfg_t          cfg_q
);

    logic sel_hit;

    always_comb begin
        sel_hit = wr_en && (wr_addr == AFN_OFFSET) && (bank_sel == AFN_BANK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sel_hit) begin
            cfg_q <= afn_cfg_t'(wr_data);
        end
    end

endmodule

// File: rtl/rs485_drv_seq.sv
module rs485_drv_seq
    import rs485_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rs485_en,
    input  logic [DLY_W-1:0] dly,
    input  logic             thr_write,
    input  logic             txfifo_empty,
    input  logic             tsr_empty,
    input  logic             bit_tick,
    output logic             drv_en
);

    drv_state_t       state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic             pending;

    always_comb begin
        pending = tx_data_pending(txfifo_empty, tsr_empty, thr_write);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            DS_IDLE: begin
                cnt_d = '0;
                if (pending) state_d = DS_SEND;
            end
            DS_SEND: begin
                if (!pending) begin
                    state_d = DS_HOLD;
                    cnt_d   = dly;
                end
            end
            DS_HOLD: begin
                if (pending) begin
                    state_d = DS_SEND;
                end else if (bit_tick) begin
                    if (cnt_q == '0) begin
                        state_d = DS_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = DS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !rs485_en) begin
            state_q <= DS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        drv_en = (state_q != DS_IDLE);
    end

endmodule

// File: rtl/rs485_irq_gate.sv
module rs485_irq_gate (
    input  logic rs485_en,
    input  logic ir_en,
    input  logic large_blk,
    input  logic rcv_en,
    input  logic loopback,
    input  logic txfifo_empty,
    input  logic tsr_empty,
    input  logic tx_below_thr,
    output logic tx_irq,
    output logic rx_store_en,
    output logic rx_timeout_en
);
    import rs485_pkg::*;

    logic tx_raw;
    logic hold_off;

    always_comb begin
        tx_raw        = tx_below_thr || txfifo_empty;
        hold_off      = rs485_en && !large_blk && !tsr_empty;
        tx_irq        = tx_raw && !hold_off;
        rx_store_en   = rx_store_allowed(rs485_en || ir_en, rcv_en, loopback);
        rx_timeout_en = rcv_en;
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              thr_write,
    input  logic              txfifo_empty,
    input  logic              tsr_empty,
    input  logic              bit_tick,
    input  logic              tx_below_thr,
    input  logic              loopback,
    output logic              drv_en,
    output logic              tx_irq,
    output logic              rx_store_en,
    output logic              rx_timeout_en
);

    afn_cfg_t cfg_q;

    rs485_afn_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .bank_sel (bank_sel),
        .wr_data  (wr_data),
        .cfg_q    (cfg_q)
    );

    rs485_drv_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .rs485_en     (cfg_q.rs485_en),
        .dly          (cfg_q.dly),
        .thr_write    (thr_write),
        .txfifo_empty (txfifo_empty),
        .tsr_empty    (tsr_empty),
        .bit_tick     (bit_tick),
        .drv_en       (drv_en)
    );

    rs485_irq_gate u_gate (
        .rs485_en      (cfg_q.rs485_en),
        .ir_en         (cfg_q.ir_en),
        .large_blk     (cfg_q.large_blk),
        .rcv_en        (cfg_q.rcv_en),
        .loopback      (loopback),
        .txfifo_empty  (txfifo_empty),
        .tsr_empty     (tsr_empty),
        .tx_below_thr  (tx_below_thr),
        .tx_irq        (tx_irq),
        .rx_store_en   (rx_store_en),
        .rx_timeout_en (rx_timeout_en)
    );

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk (
    input logic clk,
    input logic rst,
    input logic thr_write,
    input logic txfifo_empty,
    input logic tsr_empty,
    input logic bit_tick,
    input logic loopback,
    input logic drv_en,
    input logic tx_irq,
    input logic rx_store_en,
    input logic rx_timeout_en,
    input logic cfg_rs485,
    input logic cfg_large,
    input logic cfg_rcv
);

    // R3
    drv_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rs485 && (thr_write || !txfifo_empty || !tsr_empty)) |=> drv_en);

    // R4
    drv_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> ($past(bit_tick && txfifo_empty && tsr_empty && !thr_write)
                           || !$past(cfg_rs485)));

    // R6
    drv_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rs485 |=> !drv_en);

    // R7
    tx_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rs485 && !cfg_large && !tsr_empty) |-> !tx_irq);

    // R10
    lb_store_chk: assert property (@(posedge clk) disable iff (rst)
        loopback |-> rx_store_en);

    // R9
    tmo_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rcv |-> !rx_timeout_en);

endmodule

bind rs485_dir_ctrl rs485_dir_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .thr_write     (thr_write),
    .txfifo_empty  (txfifo_empty),
    .tsr_empty     (tsr_empty),
    .bit_tick      (bit_tick),
    .loopback      (loopback),
    .drv_en        (drv_en),
    .tx_irq        (tx_irq),
    .rx_store_en   (rx_store_en),
    .rx_timeout_en (rx_timeout_en),
    .cfg_rs485     (cfg_q.rs485_en),
    .cfg_large     (cfg_q.large_blk),
    .cfg_rcv       (cfg_q.rcv_en)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [2:0] bank_sel;
    logic [7:0] wr_data;
    logic       thr_write, txfifo_empty, tsr_empty, bit_tick, tx_below_thr, loopback;
    logic       drv_en, tx_irq, rx_store_en, rx_timeout_en;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rs485_dir_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .bank_sel(bank_sel),
        .wr_data(wr_data), .thr_write(thr_write), .txfifo_empty(txfifo_empty),
        .tsr_empty(tsr_empty), .bit_tick(bit_tick), .tx_below_thr(tx_below_thr),
        .loopback(loopback), .drv_en(drv_en), .tx_irq(tx_irq),
        .rx_store_en(rx_store_en), .rx_timeout_en(rx_timeout_en)
    );

    // {cfg[7:0], loopback, fifo_empty, tsr_empty, below_thr, exp_tx, exp_store, exp_tmo}
    localparam int NVEC = 13;
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h00, 4'b0001, 3'b110},
        {8'h10, 4'b0000, 3'b011},
        {8'h04, 4'b0001, 3'b000},
        {8'h04, 4'b0110, 3'b100},
        {8'h0C, 4'b0001, 3'b100},
        {8'h14, 4'b0100, 3'b011},
        {8'h02, 4'b0011, 3'b100},
        {8'h02, 4'b1010, 3'b010},
        {8'h04, 4'b1000, 3'b010},
        {8'h12, 4'b0110, 3'b111},
        {8'h01, 4'b0000, 3'b010},
        {8'h1C, 4'b1001, 3'b111},
        {8'h04, 4'b0101, 3'b000}
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [2:0] b, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; bank_sel = b; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        cycle();
        bit_tick = 1'b0;
        cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycle();
        cycle();
        rst = 1'b0;
        cycle();
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; bank_sel = 0; wr_data = 0;
        thr_write = 0; txfifo_empty = 1; tsr_empty = 1; bit_tick = 0;
        tx_below_thr = 0; loopback = 0;
        @(negedge clk);
        do_reset();

        // R2 reset state
        check("R2 drv_en", drv_en, 1'b0);
        check("R2 tx_irq", tx_irq, 1'b1);
        check("R2 rx_store_en", rx_store_en, 1'b1);
        check("R2 rx_timeout_en", rx_timeout_en, 1'b0);

        // Gating table: R7 R8 R9 R10 R11
        for (int i = 0; i < NVEC; i++) begin
            host_wr(3'b010, 3'b100, VEC[i][14:7]);
            loopback     = VEC[i][6];
            txfifo_empty = VEC[i][5];
            tsr_empty    = VEC[i][4];
            tx_below_thr = VEC[i][3];
            #1;
            check($sformatf("R7 tx_irq vec%0d", i), tx_irq, VEC[i][2]);
            check($sformatf("R8/R10 rx_store_en vec%0d", i), rx_store_en, VEC[i][1]);
            check($sformatf("R9 rx_timeout_en vec%0d", i), rx_timeout_en, VEC[i][0]);
        end
        loopback = 0; txfifo_empty = 1; tsr_empty = 1; tx_below_thr = 0;
        do_reset();

        // R1: wrong bank and wrong offset are ignored
        host_wr(3'b010, 3'b000, 8'h14);
        host_wr(3'b011, 3'b100, 8'h14);
        check("R1 ignored write timeout", rx_timeout_en, 1'b0);
        txfifo_empty = 0;
        cycle();
        check("R1 ignored write drv_en", drv_en, 1'b0);
        txfifo_empty = 1;

        // R11: IrDA plus reserved bit never drive the line
        host_wr(3'b010, 3'b100, 8'h03);
        txfifo_empty = 0; tsr_empty = 0;
        cycle();
        check("R11 irda drv_en", drv_en, 1'b0);
        check("R11 irda tx_irq normal", tx_irq, 1'b0);
        txfifo_empty = 1; tsr_empty = 1;

        // R3/R4: delay 3 -> released on the 4th tick
        host_wr(3'b010, 3'b100, 8'h64);
        check("R3 idle before data", drv_en, 1'b0);
        txfifo_empty = 0;
        cycle();
        check("R3 drv_en rise", drv_en, 1'b1);
        tick();
        tsr_empty = 0; txfifo_empty = 1;
        tick();
        check("R4 ticks while pending ignored", drv_en, 1'b1);
        tsr_empty = 1;
        cycle();
        repeat (5) cycle();
        check("R4 no tick holds", drv_en, 1'b1);
        tick(); tick(); tick();
        check("R4 after D ticks", drv_en, 1'b1);
        tick();
        check("R4 after D+1 ticks", drv_en, 1'b0);

        // R4 with D=0: first tick releases
        host_wr(3'b010, 3'b100, 8'h04);
        thr_write = 1;
        cycle();
        thr_write = 0;
        check("R3 thr_write rise", drv_en, 1'b1);
        cycle();
        check("R4 D0 before tick", drv_en, 1'b1);
        tick();
        check("R4 D0 first tick", drv_en, 1'b0);

        // R5: cancel and restart with D=2
        host_wr(3'b010, 3'b100, 8'h44);
        txfifo_empty = 0;
        cycle();
        txfifo_empty = 1;
        cycle();
        tick(); tick();
        thr_write = 1;
        cycle();
        thr_write = 0;
        check("R5 cancel keeps drv_en", drv_en, 1'b1);
        cycle();
        tick(); tick();
        check("R5 count restarted", drv_en, 1'b1);
        tick();
        check("R5 release after restart", drv_en, 1'b0);

        // R6: disable in the middle of a countdown
        host_wr(3'b010, 3'b100, 8'hE4);
        txfifo_empty = 0;
        cycle();
        txfifo_empty = 1;
        cycle();
        tick();
        check("R6 counting", drv_en, 1'b1);
        host_wr(3'b010, 3'b100, 8'hE0);
        cycle();
        check("R6 disabled drops", drv_en, 1'b0);
        txfifo_empty = 0;
        cycle();
        check("R6 disabled stays low", drv_en, 1'b0);
        txfifo_empty = 1;

        // R2 again: reset clears configuration mid-operation
        host_wr(3'b010, 3'b100, 8'h14);
        do_reset();
        check("R2 reset clears rcv_en", rx_timeout_en, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule